// File: doc/BRIEF.md
# Dual-Basis GF(2^m) Multiplier

This block multiplies two elements of the binary extension field GF(2^m). The field is fixed at elaboration by a degree parameter and an irreducible field polynomial. Both operands enter in polynomial (standard) basis, and the product leaves in standard basis. This lets the block sit in a datapath that never sees any other representation.

Inside, only operand `b_in` is re-expressed in dual coordinates. A dual coordinate is the trace of the element times a power of the root. A linear recurrence taken from the field polynomial then stretches those m coordinates to 2m-1 values. Each dual coordinate of the product is the GF(2) inner product of `a_in` with a sliding length-m window of that sequence, and an inverse matrix returns the product to standard basis. Both conversion matrices are derived from the polynomial by constant functions during elaboration.

An optional output register adds one cycle of latency, a valid flag and a synchronous active-high reset. With the register removed, the path is purely combinational.

Top module: `dual_basis_mul`

## Requirements
- R1: With REG_OUT=1, if `in_valid` is high at a rising edge, `p_out` after that edge equals `a_in`·`b_in` reduced modulo POLY. Bit i of any operand or result is the coefficient of x^i, and POLY defaults to 9'h11B for M=8.
- R2: If either operand is the zero element (all bits 0), the product is 0.
- R3: If one operand is the unit element (value 1, only bit 0 set), the product equals the other operand bit for bit. This is the full to-dual, window, to-standard round trip.
- R4: The product does not depend on which port carries which operand, even though only `b_in` is converted to dual coordinates.
- R5: With REG_OUT=1, `p_valid` after a rising edge equals `in_valid` sampled at that edge (one-cycle latency).
- R6: With REG_OUT=1, if `in_valid` is low at a rising edge, `p_out` keeps its previous value whatever the operands are.
- R7: With REG_OUT=1, `rst` high at a rising edge clears `p_out` to 0 and `p_valid` to 0, even while `in_valid` is high.
- R8: The same RTL gives correct products for other degrees and polynomials supplied as parameters: M=5 with POLY=6'b100101 and M=16 with POLY=17'h1100B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and the product is to be captured |
| a_in | input | M | Operand used directly in standard basis |
| b_in | input | M | Operand converted to dual basis inside |
| p_out | output | M | Product in standard basis |
| p_valid | output | 1 | Product on `p_out` is valid |

## Verification
A wrong matrix entry or a wrong recurrence tap corrupts only certain products. It does so immediately and without any state, so the fault shows on `p_out` at the first edge that captures an affected operand pair. That is why the default field is swept over every operand pair, and the other two fields are swept or sampled widely. The unit-operand cases expose a mismatch between the two conversion matrices directly, because the array then acts as a pass-through. The register faults in valid, hold or reset behaviour appear one cycle after the edge that causes them.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int MAXM = 16;
  typedef logic [MAXM-1:0] fe_t;
  typedef logic [MAXM-1:0][MAXM-1:0] mat_t;  // [row][column]

  function automatic fe_t fe_mask(int m);
    fe_t r;
    if (m >= MAXM) r = '1;
    else r = fe_t'((32'd1 << m) - 32'd1);
    return r;
  endfunction

  // Shift-and-add multiply, operand a walks up through the powers of x
  function automatic fe_t fmul(int m, logic [MAXM:0] poly, fe_t a, fe_t b);
    fe_t acc, sh, msk;
    logic top;
    msk = fe_mask(m);
    acc = '0;
    sh  = a & msk;
    for (int i = 0; i < MAXM; i++) begin
      if (i < m) begin
        if (b[i]) acc = acc ^ sh;
        top = sh[m-1];
        sh  = (sh << 1) & msk;
        if (top) sh = sh ^ (poly[MAXM-1:0] & msk);
      end
    end
    return acc;
  endfunction

  // Absolute trace: sum of the m Frobenius conjugates, which lands in GF(2)
  function automatic logic ftrace(int m, logic [MAXM:0] poly, fe_t y);
    fe_t acc, s;
    acc = '0;
    s   = y;
    for (int k = 0; k < MAXM; k++) begin
      if (k < m) begin
        acc = acc ^ s;
        s   = fmul(m, poly, s, s);
      end
    end
    return acc[0];
  endfunction

  // Bit n is the trace of x^n, for n = 0 .. 2m-2
  function automatic logic [2*MAXM-2:0] trace_seq(int m, logic [MAXM:0] poly);
    logic [2*MAXM-2:0] t;
    fe_t p;
    t = '0;
    p = fe_t'(1);
    for (int n = 0; n < 2*MAXM-1; n++) begin
      if (n < 2*m-1) begin
        t[n] = ftrace(m, poly, p);
        p    = fmul(m, poly, p, fe_t'(2));
      end
    end
    return t;
  endfunction

  // Inverse over GF(2) of the Hankel trace matrix T[r][c] = Tr(x^(r+c))
  function automatic mat_t d2s_matrix(int m, logic [MAXM:0] poly);
    logic [2*MAXM-2:0] t;
    mat_t a, inv;
    fe_t tmp;
    int piv;
    t = trace_seq(m, poly);
    a = '0;
    inv = '0;
    for (int r = 0; r < m; r++) begin
      for (int c = 0; c < m; c++) a[r][c] = t[r+c];
      inv[r][r] = 1'b1;
    end
    for (int c = 0; c < m; c++) begin
      piv = -1;
      for (int r = c; r < m; r++)
        if (piv < 0 && a[r][c]) piv = r;
      if (piv >= 0) begin
        tmp = a[c];   a[c]   = a[piv];   a[piv]   = tmp;
        tmp = inv[c]; inv[c] = inv[piv]; inv[piv] = tmp;
        for (int r = 0; r < m; r++) begin
          if (r != c && a[r][c]) begin
            a[r]   = a[r] ^ a[c];
            inv[r] = inv[r] ^ inv[c];
          end
        end
      end
    end
    return inv;
  endfunction
endpackage

// File: rtl/dbm_to_dual.sv
module dbm_to_dual #(
  parameter int unsigned M = 8,
  parameter logic [M:0]  POLY = 9'h11B
) (
  input  logic [M-1:0] x_std,
  output logic [M-1:0] x_dual
);
  localparam logic [dbm_pkg::MAXM:0] PX = (dbm_pkg::MAXM+1)'(POLY);
  localparam logic [2*dbm_pkg::MAXM-2:0] TSEQ = dbm_pkg::trace_seq(M, PX);

  // Row i of the conversion matrix is the trace sequence shifted by i
  for (genvar i = 0; i < M; i++) begin : g_row
    assign x_dual[i] = ^(x_std & TSEQ[i +: M]);
  end
endmodule

// File: rtl/dbm_extend.sv
module dbm_extend #(
  parameter int unsigned M = 8,
  parameter logic [M:0]  POLY = 9'h11B
) (
  input  logic [M-1:0]   d_in,
  output logic [2*M-2:0] d_ext
);
  logic [2*M-2:0] seq;

  // Each new dual coordinate follows from the m before it via the field polynomial taps
  always_comb begin
    seq = '0;
    seq[M-1:0] = d_in;
    for (int j = 0; j < M-1; j++)
      seq[M+j] = ^(POLY[M-1:0] & seq[j +: M]);
  end

  assign d_ext = seq;
endmodule

// File: rtl/dbm_inner.sv
module dbm_inner #(
  parameter int unsigned M = 8
) (
  input  logic [M-1:0]   a_std,
  input  logic [2*M-2:0] d_ext,
  output logic [M-1:0]   c_dual
);
  // m*m AND terms and m*(m-1) XOR terms: one window-wide inner product per output
  for (genvar j = 0; j < M; j++) begin : g_win
    assign c_dual[j] = ^(a_std & d_ext[j +: M]);
  end
endmodule

// File: rtl/dbm_to_std.sv
module dbm_to_std #(
  parameter int unsigned M = 8,
  parameter logic [M:0]  POLY = 9'h11B
) (
  input  logic [M-1:0] y_dual,
  output logic [M-1:0] y_std
);
  localparam logic [dbm_pkg::MAXM:0] PX = (dbm_pkg::MAXM+1)'(POLY);
  localparam dbm_pkg::mat_t INV = dbm_pkg::d2s_matrix(M, PX);

  for (genvar r = 0; r < M; r++) begin : g_row
    assign y_std[r] = ^(y_dual & INV[r][M-1:0]);
  end
endmodule

// File: rtl/dual_basis_mul.sv
module dual_basis_mul #(
  parameter int unsigned M = 8,
  parameter logic [M:0]  POLY = 9'h11B,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic [M-1:0] p_out,
  output logic         p_valid
);
  localparam int unsigned EXTW = 2*M - 1;

  logic [M-1:0]      b_dual;
  logic [EXTW-1:0]   b_ext;
  logic [M-1:0]      c_dual;
  logic [M-1:0]      c_std;

  dbm_to_dual #(.M(M), .POLY(POLY)) i_to_dual (.x_std(b_in), .x_dual(b_dual));
  dbm_extend  #(.M(M), .POLY(POLY)) i_extend  (.d_in(b_dual), .d_ext(b_ext));
  dbm_inner   #(.M(M))              i_inner   (.a_std(a_in), .d_ext(b_ext), .c_dual(c_dual));
  dbm_to_std  #(.M(M), .POLY(POLY)) i_to_std  (.y_dual(c_dual), .y_std(c_std));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        p_out   <= '0;
        p_valid <= 1'b0;
      end else begin
        p_valid <= in_valid;
        if (in_valid) p_out <= c_std;
      end
    end
  end else begin : g_comb
    assign p_out   = c_std;
    assign p_valid = in_valid;
  end
endmodule

// File: rtl/dual_basis_mul_chk.sv
module dual_basis_mul_chk #(
  parameter int unsigned M = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] a_in,
  input logic [M-1:0] b_in,
  input logic [M-1:0] b_dual,
  input logic [M-1:0] c_dual,
  input logic [M-1:0] c_std,
  input logic [M-1:0] p_out,
  input logic         p_valid
);
  localparam logic [M-1:0] ONE = M'(1);

  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0) |-> (c_std == '0));
  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
    (b_in == '0) |-> (c_std == '0));
  a_r3_unit_a: assert property (@(posedge clk) disable iff (rst)
    (a_in == ONE) |-> (c_std == b_in));
  a_r3_unit_b: assert property (@(posedge clk) disable iff (rst)
    (b_in == ONE) |-> (c_std == a_in));
  a_r3_window_pass: assert property (@(posedge clk) disable iff (rst)
    (a_in == ONE) |-> (c_dual == b_dual));

  if (REG_OUT) begin : g_reg_chk
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (p_out == $past(c_std)));
    a_r5_valid_set: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> p_valid);
    a_r5_valid_clr: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !p_valid);
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(p_out));
  end
endmodule

bind dual_basis_mul dual_basis_mul_chk #(.M(M), .REG_OUT(REG_OUT)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .b_dual(b_dual), .c_dual(c_dual), .c_std(c_std), .p_out(p_out), .p_valid(p_valid)
);

// File: tb/test_dual_basis_mul.sv
`timescale 1ns/1ps
module test_dual_basis_mul;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [4:0]  a5 = '0, b5 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [7:0]  p8;
  logic [4:0]  p5;
  logic [15:0] p16;
  logic v8, v5, v16;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_basis_mul #(.M(8), .POLY(9'h11B), .REG_OUT(1'b1)) i_dual_basis_mul (
    .clk(clk), .rst(rst), .in_valid(vld), .a_in(a8), .b_in(b8), .p_out(p8), .p_valid(v8));
  dual_basis_mul #(.M(5), .POLY(6'b100101), .REG_OUT(1'b1)) i_dual_basis_mul_m5 (
    .clk(clk), .rst(rst), .in_valid(vld), .a_in(a5), .b_in(b5), .p_out(p5), .p_valid(v5));
  dual_basis_mul #(.M(16), .POLY(17'h1100B), .REG_OUT(1'b1)) i_dual_basis_mul_m16 (
    .clk(clk), .rst(rst), .in_valid(vld), .a_in(a16), .b_in(b16), .p_out(p16), .p_valid(v16));

  // Horner-style reference: walk b from its top bit down, doubling and reducing
  function automatic int ref_mul(int m, int poly, int a, int b);
    int r = 0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (((r >> m) & 1) != 0) r = r ^ poly;
      if (((b >> i) & 1) != 0) r = r ^ a;
    end
    return r;
  endfunction

  function automatic string tag_of(int a, int b);
    if (a == 0 || b == 0) return "R2";
    if (a == 1 || b == 1) return "R3";
    if (a > b) return "R4";
    return "R1";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one operand set at the falling edge, check after the capturing rising edge
  task automatic step(bit v, int xa8, int xb8, int xa5, int xb5, int xa16, int xb16,
                      string r8, string r5, string r16);
    @(negedge clk);
    vld = v;
    a8 = 8'(xa8);    b8 = 8'(xb8);
    a5 = 5'(xa5);    b5 = 5'(xb5);
    a16 = 16'(xa16); b16 = 16'(xb16);
    @(posedge clk);
    #1;
    if (v && !rst) begin
      check(r8,  "m8 product",  int'(p8),  ref_mul(8, 'h11B, xa8 & 'hFF, xb8 & 'hFF));
      check(r5,  "m5 product",  int'(p5),  ref_mul(5, 'h25, xa5 & 'h1F, xb5 & 'h1F));
      check(r16, "m16 product", int'(p16), ref_mul(16, 'h1100B, xa16 & 'hFFFF, xb16 & 'hFFFF));
    end
  endtask

  initial begin
    int last8;
    int ra, rb;
    void'($urandom(32'd20240611));
    // R7: reset dominates even with valid operands
    vld = 1'b1; a8 = 8'h57; b8 = 8'h83;
    repeat (3) @(posedge clk);
    #1;
    check("R7", "p_out in reset", int'(p8), 0);
    check("R7", "p_valid in reset", int'(v8), 0);
    check("R7", "m16 p_valid in reset", int'(v16), 0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corners, M=16 and the others
    step(1, 0, 'hA5, 0, 7, 0, 'hBEEF, "R2", "R2", "R2");
    step(1, 'h3C, 0, 9, 0, 'h1234, 0, "R2", "R2", "R2");
    step(1, 1, 'hC3, 1, 'h1B, 1, 'h8001, "R3", "R3", "R3");
    step(1, 'h9E, 1, 'h16, 1, 'hFACE, 1, "R3", "R3", "R3");
    step(1, 'hFF, 'hFF, 'h1F, 'h1F, 'hFFFF, 'hFFFF, "R1", "R8", "R8");
    step(1, 'h80, 'h80, 'h10, 'h10, 'h8000, 'h8000, "R1", "R8", "R8");
    step(1, 'h57, 'h83, 'h0B, 'h15, 'h00C1, 'h5A5A, "R1", "R8", "R8");
    step(1, 'h83, 'h57, 'h15, 'h0B, 'h5A5A, 'h00C1, "R4", "R4", "R4");

    // Exhaustive M=8 and M=5 sweep, constrained random M=16 pairs
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        ra = int'($urandom() & 32'hFFFF);
        rb = int'($urandom() & 32'hFFFF);
        if ((b & 63) == 0) rb = 1;
        step(1, a, b, a & 31, b & 31, ra, rb, tag_of(a, b), "R8", "R8");
      end
    end

    // R5 valid follows in_valid; R6 hold while idle
    step(1, 'h02, 'h87, 3, 4, 2, 'h8000, "R1", "R8", "R8");
    last8 = int'(p8);
    check("R5", "p_valid after valid cycle", int'(v8), 1);
    step(0, 'h11, 'h22, 5, 6, 'h77, 'h99, "R6", "R6", "R6");
    check("R5", "p_valid after idle cycle", int'(v8), 0);
    check("R6", "p_out held while idle", int'(p8), last8);
    step(0, 'hF0, 'h0F, 1, 2, 'h1, 'h2, "R6", "R6", "R6");
    check("R6", "p_out still held", int'(p8), last8);
    check("R5", "m5 p_valid idle", int'(v5), 0);
    step(1, 'h0D, 'h0E, 'h0D, 'h0E, 'hD, 'hE, "R1", "R8", "R8");
    check("R5", "p_valid restored", int'(v8), 1);

    // R7: mid-run reset clears the register
    @(negedge clk);
    rst = 1'b1; vld = 1'b1; a8 = 8'h33; b8 = 8'h44;
    @(posedge clk);
    #1;
    check("R7", "p_out after reset", int'(p8), 0);
    check("R7", "p_valid after reset", int'(v8), 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule